// File: doc/BRIEF.md
# SPI Status Flag Controller

This block holds the status flags of an 8-bit serial port and sits between the processor bus and the shift engine. It keeps three sticky flags: transfer complete, write collision and mode fault. It decides when a CPU write may reach the data register, and it raises a level interrupt while a completed transfer is pending and interrupts are enabled.

A flag is cleared in two steps. First the CPU reads the status byte while the flag is set. Then, in a later cycle, it accesses the data register by either a read or a write. Until that status read has happened, a pending transfer-complete flag blocks data writes. The block also tracks the transfer window from the serial clock, the slave-select line and the clock-phase setting. A data write made while the window is open counts as a collision and is kept away from the shifter.

The serial clock and select pins are resynchronised inside the block, so pin activity shows up a few system clocks late. All flags change only on the system clock.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset the status byte is 0x00 and the interrupt request is low.
- R2: The status byte carries transfer-complete in bit 7, write-collision in bit 6 and mode-fault in bit 4. Bits 5 and 3..0 always read 0.
- R3: A done pulse from the shifter sets transfer-complete on the next clock. The interrupt request is high exactly while transfer-complete and the interrupt enable are both 1.
- R4: A set flag clears only when two things happen in order. First a status read is made while the flag is set. Then, in a later cycle, a data-register read or write is made. A data access with no such earlier read leaves the flag set.
- R5: While transfer-complete is set and its status read has not yet happened, a data write does not raise the write enable. Once that read has happened, the write is passed on (if no window is open) and clears the flag.
- R6: A data write while the transfer window is open sets write-collision on the next clock and does not raise the write enable. The collision clears by the same two-step sequence as in R4.
- R7: With clock phase 0, the window opens when the select line falls and closes when it rises. Serial clock edges do not open it.
- R8: With clock phase 1, the window opens at the first serial clock transition seen while select is low, and closes when the done pulse arrives.
- R9: Mode-fault sets while master mode is on and the synchronised select line is low. In slave mode a low select line does not set it.
- R10: If a set event and a clearing access fall in the same cycle, the flag ends up set.
- R11: Each clearing access uses up the status read that armed it. A status read made in the same cycle as a data access does not arm that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_rd | input | 1 | One-cycle strobe: CPU reads the status byte |
| data_rd | input | 1 | One-cycle strobe: CPU reads the data register |
| data_wr | input | 1 | One-cycle strobe: CPU writes the data register |
| sck | input | 1 | Serial clock pin (asynchronous) |
| ss_n | input | 1 | Active-low slave-select pin (asynchronous) |
| cpha | input | 1 | Clock phase setting |
| master | input | 1 | 1 = master mode |
| irq_en | input | 1 | Interrupt enable |
| xfer_done | input | 1 | One-cycle pulse from the shifter at the end of a byte |
| status | output | 8 | Status byte |
| irq | output | 1 | Level interrupt request |
| data_wr_en | output | 1 | Write to the data register is allowed this cycle |

## Verification
Two situations need the same cycle to carry more than one event. In the first, a done pulse arrives in the same cycle as an armed clearing access. In the second, a status read and a data access arrive together. Both are driven as directed cycles. The result is judged on the status byte one clock later, which must show the flag still set. A seeded random run then mixes status reads, data accesses and done pulses. Every cycle is compared against a bench model of the flag, its armed bit and the write gate.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

    // Flag slots, in the order the flag array is built.
    localparam int FLAG_CNT  = 3;
    localparam int IDX_DONE  = 0;
    localparam int IDX_COLL  = 1;
    localparam int IDX_FAULT = 2;

    // Bit positions of the flags in the status byte.
    localparam int STAT_W         = 8;
    localparam int STAT_DONE_BIT  = 7;
    localparam int STAT_COLL_BIT  = 6;
    localparam int STAT_FAULT_BIT = 4;

    // State of one sticky flag.
    typedef struct packed {
        logic flag;
        logic arm;
    } flag_state_t;

    // State of the transfer-window tracker.
    typedef struct packed {
        logic open;
    } win_state_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], pin};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{RST_VAL}};
            st_q.prev  <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.chain[STAGES-1];
    assign rise  = st_q.chain[STAGES-1] & ~st_q.prev;
    assign fall  = ~st_q.chain[STAGES-1] & st_q.prev;

endmodule

// File: rtl/spi_xfer_window.sv
module spi_xfer_window
    import spi_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpha,
    input  logic ss_n_lvl,
    input  logic ss_n_fall,
    input  logic ss_n_rise,
    input  logic sck_edge,
    input  logic done,
    output logic open
);

    win_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!cpha) begin
            // Phase 0: the select line alone bounds the window.
            if (ss_n_fall)      st_d.open = 1'b1;
            else if (ss_n_rise) st_d.open = 1'b0;
        end else begin
            // Phase 1: the first clock transition opens it, end of byte closes it.
            if (done)                      st_d.open = 1'b0;
            else if (sck_edge && !ss_n_lvl) st_d.open = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.open <= 1'b0;
        else        st_q      <= st_d;
    end

    assign open = st_q.open;

endmodule

// File: rtl/spi_sticky_flag.sv
module spi_sticky_flag
    import spi_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic stat_rd,
    input  logic access,
    output logic flag,
    output logic armed
);

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // A set event wins over a clearing access in the same cycle.
        if (set)
            st_d.flag = 1'b1;
        else if (access && st_q.arm && st_q.flag)
            st_d.flag = 1'b0;

        // Any data access uses up the arm. A status read only arms while the flag is set.
        if (access || !st_q.flag)
            st_d.arm = 1'b0;
        else if (stat_rd)
            st_d.arm = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag <= 1'b0;
            st_q.arm  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag  = st_q.flag;
    assign armed = st_q.arm;

endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
    import spi_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic              sck,
    input  logic              ss_n,
    input  logic              cpha,
    input  logic              master,
    input  logic              irq_en,
    input  logic              xfer_done,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    output logic              data_wr_en
);

    logic sck_lvl, sck_rise, sck_fall;
    logic ss_n_s, ss_n_rise, ss_n_fall;
    logic win_open;
    logic data_access;
    logic [FLAG_CNT-1:0] set_vec, flag_vec, arm_vec;

    spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .pin(sck),
        .level(sck_lvl), .rise(sck_rise), .fall(sck_fall)
    );

    spi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ss_sync (
        .clk(clk), .rst_n(rst_n), .pin(ss_n),
        .level(ss_n_s), .rise(ss_n_rise), .fall(ss_n_fall)
    );

    spi_xfer_window u_win (
        .clk(clk), .rst_n(rst_n), .cpha(cpha),
        .ss_n_lvl(ss_n_s), .ss_n_fall(ss_n_fall), .ss_n_rise(ss_n_rise),
        .sck_edge(sck_rise | sck_fall), .done(xfer_done), .open(win_open)
    );

    assign data_access = data_rd | data_wr;

    always_comb begin
        set_vec            = '0;
        set_vec[IDX_DONE]  = xfer_done;
        set_vec[IDX_COLL]  = data_wr & win_open;
        set_vec[IDX_FAULT] = master & ~ss_n_s;
    end

    for (genvar g = 0; g < FLAG_CNT; g++) begin : g_flag
        spi_sticky_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set(set_vec[g]),
            .stat_rd(stat_rd), .access(data_access),
            .flag(flag_vec[g]), .armed(arm_vec[g])
        );
    end

    always_comb begin
        status                 = '0;
        status[STAT_DONE_BIT]  = flag_vec[IDX_DONE];
        status[STAT_COLL_BIT]  = flag_vec[IDX_COLL];
        status[STAT_FAULT_BIT] = flag_vec[IDX_FAULT];
    end

    assign irq        = flag_vec[IDX_DONE] & irq_en;
    assign data_wr_en = data_wr & ~win_open
                        & ~(flag_vec[IDX_DONE] & ~arm_vec[IDX_DONE]);

    // sck_lvl is only needed for edge detection.
    logic unused_ok;
    assign unused_ok = sck_lvl;

endmodule

// File: rtl/spi_flag_ctrl_chk.sv
module spi_flag_ctrl_chk
    import spi_flag_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              data_rd,
    input logic              data_wr,
    input logic              xfer_done,
    input logic              master,
    input logic              ss_n_s,
    input logic              win_open,
    input logic              done_armed,
    input logic [STAT_W-1:0] status,
    input logic              data_wr_en
);

    // R3
    done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> status[STAT_DONE_BIT]);

    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[STAT_DONE_BIT] && !(done_armed && (data_rd || data_wr))
        |=> status[STAT_DONE_BIT]);

    // R5
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr_en |-> !win_open && !(status[STAT_DONE_BIT] && !done_armed));

    // R6
    coll_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && win_open |=> status[STAT_COLL_BIT]);

    // R9
    fault_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master && !ss_n_s |=> status[STAT_FAULT_BIT]);

endmodule

bind spi_flag_ctrl spi_flag_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .data_rd(data_rd), .data_wr(data_wr),
    .xfer_done(xfer_done), .master(master), .ss_n_s(ss_n_s),
    .win_open(win_open), .done_armed(arm_vec[0]),
    .status(status), .data_wr_en(data_wr_en)
);

// File: tb/sim_spi_flag_ctrl.sv
`timescale 1ns/1ps
module sim_spi_flag_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stat_rd = 0, data_rd = 0, data_wr = 0, xfer_done = 0;
    logic sck = 0, ss_n = 1, cpha = 0, master = 0, irq_en = 0;
    logic [7:0] status;
    logic irq, data_wr_en;
    logic wr_seen;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_flag_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_rd(data_rd),
        .data_wr(data_wr), .sck(sck), .ss_n(ss_n), .cpha(cpha),
        .master(master), .irq_en(irq_en), .xfer_done(xfer_done),
        .status(status), .irq(irq), .data_wr_en(data_wr_en)
    );

    task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_stat(input string req, input logic [7:0] exp);
        chk(status == exp, req, status, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one strobe cycle, record the write enable during it, then return one cycle later.
    task automatic pulse(input logic sr, input logic dr, input logic dw, input logic dn);
        @(negedge clk);
        stat_rd = sr; data_rd = dr; data_wr = dw; xfer_done = dn;
        #1 wr_seen = data_wr_en;
        @(negedge clk);
        stat_rd = 0; data_rd = 0; data_wr = 0; xfer_done = 0;
        #1;
    endtask

    // Bench model: expected write enable when no window is open.
    function automatic logic exp_wr(input logic dw, input logic f, input logic a);
        return dw & ~(f & ~a);
    endfunction

    // Bench model: expected next value of the transfer-complete flag.
    function automatic logic exp_flag(input logic dn, input logic acc, input logic f, input logic a);
        if (dn) return 1'b1;
        if (acc && a && f) return 1'b0;
        return f;
    endfunction

    // Bench model: expected next value of the armed bit.
    function automatic logic exp_arm(input logic sr, input logic acc, input logic f, input logic a);
        if (acc || !f) return 1'b0;
        return a | sr;
    endfunction

    initial begin
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic mf, ma;
        int seed_v;
        seed_v = $urandom(32'h5eed);
        idle(3);
        // R1
        chk_stat("R1", 8'h00);
        chk(irq == 1'b0, "R1", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        idle(2);
        chk_stat("R1", 8'h00);

        // R3 R4 R5 R2: set, blocked write, armed write clears
        irq_en = 1;
        pulse(0, 0, 0, 1);
        chk_stat("R3", 8'h80);
        chk(irq == 1'b1, "R3", {7'b0, irq}, 8'h01);
        pulse(0, 0, 1, 0);
        chk(wr_seen == 1'b0, "R5", {7'b0, wr_seen}, 8'h00);
        chk_stat("R4", 8'h80);
        pulse(1, 0, 0, 0);
        pulse(0, 0, 1, 0);
        chk(wr_seen == 1'b1, "R5", {7'b0, wr_seen}, 8'h01);
        chk_stat("R4", 8'h00);
        chk(irq == 1'b0, "R3", {7'b0, irq}, 8'h00);

        // R11: a status read in the same cycle as an access does not arm that access
        pulse(0, 0, 0, 1);
        pulse(1, 1, 0, 0);
        chk_stat("R11", 8'h80);
        pulse(0, 1, 0, 0);
        chk_stat("R11", 8'h80);
        pulse(1, 0, 0, 0);
        pulse(0, 1, 0, 0);
        chk_stat("R4", 8'h00);

        // R10: a set and a clearing access together leave the flag set; the arm is used up
        pulse(0, 0, 0, 1);
        pulse(1, 0, 0, 0);
        pulse(0, 1, 0, 1);
        chk_stat("R10", 8'h80);
        pulse(0, 1, 0, 0);
        chk_stat("R11", 8'h80);
        pulse(1, 0, 0, 0);
        pulse(0, 1, 0, 0);
        chk_stat("R10", 8'h00);

        // R7 R6: phase 0 window from select
        cpha = 0;
        sck = 1; idle(6); sck = 0; idle(6);
        pulse(0, 0, 1, 0);
        chk(wr_seen == 1'b1, "R7", {7'b0, wr_seen}, 8'h01);
        ss_n = 0; idle(6);
        pulse(0, 0, 1, 0);
        chk(wr_seen == 1'b0, "R6", {7'b0, wr_seen}, 8'h00);
        chk_stat("R6", 8'h40);
        ss_n = 1; idle(6);
        pulse(0, 0, 1, 0);
        chk(wr_seen == 1'b1, "R7", {7'b0, wr_seen}, 8'h01);
        chk_stat("R6", 8'h40);
        pulse(1, 0, 0, 0);
        pulse(0, 1, 0, 0);
        chk_stat("R6", 8'h00);

        // R8: phase 1 window from first clock transition, closed by done
        cpha = 1;
        ss_n = 0; idle(6);
        pulse(0, 0, 1, 0);
        chk(wr_seen == 1'b1, "R8", {7'b0, wr_seen}, 8'h01);
        chk_stat("R8", 8'h00);
        sck = 1; idle(6);
        pulse(0, 0, 1, 0);
        chk(wr_seen == 1'b0, "R8", {7'b0, wr_seen}, 8'h00);
        chk_stat("R6", 8'h40);
        pulse(0, 0, 0, 1);
        chk_stat("R8", 8'hC0);
        pulse(1, 0, 0, 0);
        pulse(0, 0, 1, 0);
        chk(wr_seen == 1'b1, "R8", {7'b0, wr_seen}, 8'h01);
        chk_stat("R8", 8'h00);
        ss_n = 1; idle(6); sck = 0; idle(6);
        cpha = 0;

        // R9: mode fault in master mode only
        master = 1; ss_n = 0; idle(6);
        chk(status[4] == 1'b1, "R9", status, 8'h10);
        master = 0; ss_n = 1; idle(6);
        pulse(1, 0, 0, 0);
        pulse(0, 1, 0, 0);
        chk_stat("R9", 8'h00);
        ss_n = 0; idle(6);
        chk(status[4] == 1'b0, "R9", status, 8'h00);
        ss_n = 1; idle(6);
        pulse(1, 0, 0, 0);
        pulse(0, 1, 0, 0);
        chk_stat("R2", 8'h00);

        // Random run with the window closed, checked against the bench model (R3 R4 R5 R11)
        mf = 0; ma = 0;
        for (int i = 0; i < 3000; i++) begin
            logic sr, dr, dw, dn, ie;
            sr = ($urandom % 100) < 30;
            dr = ($urandom % 100) < 15;
            dw = ($urandom % 100) < 15;
            dn = ($urandom % 100) < 10;
            ie = $urandom % 2;
            @(negedge clk);
            stat_rd = sr; data_rd = dr; data_wr = dw; xfer_done = dn; irq_en = ie;
            #1;
            chk_stat("R4", {mf, 7'b0});
            chk(data_wr_en == exp_wr(dw, mf, ma), "R5", {7'b0, data_wr_en}, {7'b0, exp_wr(dw, mf, ma)});
            chk(irq == (mf & ie), "R3", {7'b0, irq}, {7'b0, mf & ie});
            begin
                logic nf, na;
                nf = exp_flag(dn, dr | dw, mf, ma);
                na = exp_arm(sr, dr | dw, mf, ma);
                mf = nf; ma = na;
            end
        end
        @(negedge clk);
        stat_rd = 0; data_rd = 0; data_wr = 0; xfer_done = 0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule